// File: doc/BRIEF.md
# Validation Event Injection Counters

This block holds four counters that software uses to schedule fault and event injection during system validation. The four sources are a reset, an interrupt, a fast interrupt and an external debug request. Each counter is loaded through a coprocessor-style register access. A start strobe from a separate operations unit then sets it running. It counts up by one on every core clock. When it rolls over from all-ones to zero it emits a single-cycle pulse on its event line and stops.

Every register access is screened by a permission check. The check looks at the security world, the privilege level, a user-access enable bit and a secure write-disable input. Each access then ends in one of three ways: it completes and returns data, it returns a placeholder of zero, or it flags an undefined-instruction exception. The debug request counter is only six bits wide and cannot be read back.

Top module: `valctr_top`

## Requirements
- R1: An access takes effect only when opcode1 is 0, the primary register number is 15 and the secondary register number is 12. Any other access changes no counter and raises neither a read response nor an exception.
- R2: A decoded access selects a counter through opcode2: 1 selects the reset counter (event bit 0), 2 the interrupt counter (bit 1), 3 the fast interrupt counter (bit 2) and 7 the debug request counter (bit 3). The responses rdValid, rdData and undefExc appear one clock after the access cycle. A granted read returns the counter value as it stood in the access cycle.
- R3: A decoded access whose opcode2 is not 1, 2, 3 or 7 changes nothing and raises neither rdValid nor undefExc.
- R4: A started counter that is not being written increases by exactly one on each clock.
- R5: When a running counter rolls over from all-ones to zero, its event bit is high for exactly the one clock in which the counter first holds zero. The counter then stops at zero.
- R6: The debug request counter keeps only wrData[5:0] on a write. It therefore rolls over after counting up from 63.
- R7: A granted read of the debug request counter returns rdValid with rdData equal to zero.
- R8: With userEnable at 0, an access with opcode2 of 1, 2, 3 or 7 from the non-secure world or from secure user mode raises undefExc and leaves the counter unchanged.
- R9: With userEnable at 1, non-secure and secure user accesses behave as secure privileged accesses do.
- R10: A write in secure privileged mode while secWrDisable is high raises undefExc and leaves the counter unchanged. Reads, and writes from the other modes, are unaffected by secWrDisable.
- R11: A write to a running counter loads the written value in place of that clock's increment, and counting continues from the loaded value.
- R12: Reset clears every counter, run flag, event bit and response output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Register access present this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| op1 | input | 3 | Opcode1 field |
| crn | input | 4 | Primary register number |
| crm | input | 4 | Secondary register number |
| op2 | input | 3 | Opcode2 field, selects the counter |
| wrData | input | 32 | Write data |
| secureWorld | input | 1 | 1 = secure world |
| privMode | input | 1 | 1 = privileged mode |
| userEnable | input | 1 | Opens access to user and non-secure modes |
| secWrDisable | input | 1 | Blocks secure privileged writes |
| startReq | input | 4 | Per-counter start strobes, bit order as in R2 |
| rdData | output | 32 | Read data |
| rdValid | output | 1 | Read completed, rdData valid |
| undefExc | output | 1 | Undefined-instruction exception for the access |
| evtPulse | output | 4 | Rollover event pulses, bit order as in R2 |

## Verification
The permission check is exercised with random combinations of world, privilege, userEnable, secWrDisable, read or write, opcode2 and decode fields. These are compared against a reference model, which separates the three outcomes and catches a write that slips through a denied access. Directed rollover runs on a wide counter and on the debug counter place the event pulse on an exact cycle. This distinguishes a counter that rolls over at the right width from one that keeps discarded upper bits. Reading a running counter immediately after a write, and again one cycle later, separates write priority from the normal increment.

// File: rtl/valctr_pkg.sv
package valctr_pkg;
  localparam int NUM_CTR = 4;
  localparam int SEL_W   = $clog2(NUM_CTR);

  typedef struct packed {
    logic [NUM_CTR-1:0] wrEn;
    logic               rdEn;
    logic [SEL_W-1:0]   rdSel;
    logic               rdZero;
  } ctrlStrb_t;
endpackage

// File: rtl/valctr_cnt.sv
module valctr_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         wrEn,
  input  logic [W-1:0] wrVal,
  output logic [W-1:0] value,
  output logic         running,
  output logic         evt
);
  logic wrap;
  assign wrap = running && !wrEn && (&value);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value   <= '0;
      running <= 1'b0;
      evt     <= 1'b0;
    end else begin
      evt <= wrap;
      if (wrEn)         value <= wrVal;
      else if (running) value <= value + 1'b1;
      if (start)        running <= 1'b1;
      else if (wrap)    running <= 1'b0;
    end
  end
endmodule

// File: rtl/valctr_ctrl.sv
module valctr_ctrl
  import valctr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      accValid,
  input  logic      accWrite,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  input  logic      secureWorld,
  input  logic      privMode,
  input  logic      userEnable,
  input  logic      secWrDisable,
  output ctrlStrb_t strb,
  output logic      rdValid,
  output logic      undefExc
);
  logic             hit, known, allowed, wrBlocked, fault, grant;
  logic [SEL_W-1:0] sel;

  always_comb begin
    hit   = accValid && (op1 == 3'd0) && (crn == 4'd15) && (crm == 4'd12);
    known = 1'b1;
    sel   = '0;
    case (op2)
      3'd1:    sel = SEL_W'(0);
      3'd2:    sel = SEL_W'(1);
      3'd3:    sel = SEL_W'(2);
      3'd7:    sel = SEL_W'(3);
      default: known = 1'b0;
    endcase
    allowed   = (secureWorld && privMode) || userEnable;
    wrBlocked = secureWorld && privMode && secWrDisable;
    fault     = hit && known && (!allowed || (accWrite && wrBlocked));
    grant     = hit && known && !fault;
    strb.wrEn = '0;
    if (grant && accWrite) strb.wrEn[sel] = 1'b1;
    strb.rdEn   = grant && !accWrite;
    strb.rdSel  = sel;
    strb.rdZero = (sel == SEL_W'(3));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      undefExc <= 1'b0;
    end else begin
      rdValid  <= strb.rdEn;
      undefExc <= fault;
    end
  end
endmodule

// File: rtl/valctr_dp.sv
module valctr_dp
  import valctr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int DBG_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_CTR-1:0] startReq,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_CTR-1:0] runFlag,
  output logic [NUM_CTR-1:0] evtPulse
);
  logic [DATA_W-1:0] vals [NUM_CTR];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam int W = (i == NUM_CTR - 1) ? DBG_W : CNT_W;
    logic [W-1:0] cv;
    valctr_cnt #(.W(W)) u_cnt (
      .clk    (clk),
      .rstN   (rstN),
      .start  (startReq[i]),
      .wrEn   (strb.wrEn[i]),
      .wrVal  (wrData[W-1:0]),
      .value  (cv),
      .running(runFlag[i]),
      .evt    (evtPulse[i])
    );
    assign vals[i] = DATA_W'(cv);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= strb.rdZero ? '0 : vals[strb.rdSel];
  end
endmodule

// File: rtl/valctr_top.sv
module valctr_top
  import valctr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int DBG_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [2:0]        op1,
  input  logic [3:0]        crn,
  input  logic [3:0]        crm,
  input  logic [2:0]        op2,
  input  logic [DATA_W-1:0] wrData,
  input  logic              secureWorld,
  input  logic              privMode,
  input  logic              userEnable,
  input  logic              secWrDisable,
  input  logic [3:0]        startReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              undefExc,
  output logic [3:0]        evtPulse
);
  ctrlStrb_t          strb;
  logic [NUM_CTR-1:0] runFlag;

  valctr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .op1(op1), .crn(crn), .crm(crm), .op2(op2),
    .secureWorld(secureWorld), .privMode(privMode),
    .userEnable(userEnable), .secWrDisable(secWrDisable),
    .strb(strb), .rdValid(rdValid), .undefExc(undefExc)
  );

  valctr_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DBG_W(DBG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .startReq(startReq), .rdData(rdData), .runFlag(runFlag),
    .evtPulse(evtPulse)
  );
endmodule

// File: rtl/valctr_chk.sv
module valctr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       accValid,
  input logic       accWrite,
  input logic [2:0] op1,
  input logic [3:0] crn,
  input logic [3:0] crm,
  input logic [2:0] op2,
  input logic       secureWorld,
  input logic       privMode,
  input logic       userEnable,
  input logic       secWrDisable,
  input logic [3:0] startReq,
  input logic       rdValid,
  input logic       undefExc,
  input logic [3:0] evtPulse,
  input logic [3:0] runFlag
);
  logic hitAcc, knownSel, lockedOut, secPriv;
  assign hitAcc    = accValid && op1 == 3'd0 && crn == 4'd15 && crm == 4'd12;
  assign knownSel  = (op2 == 3'd1) || (op2 == 3'd2) || (op2 == 3'd3) || (op2 == 3'd7);
  assign secPriv   = secureWorld && privMode;
  assign lockedOut = !secPriv && !userEnable;

  a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !hitAcc) |=> (!rdValid && !undefExc));

  a_r3_bad_sel_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (hitAcc && !knownSel) |=> (!rdValid && !undefExc));

  a_r8_locked_out: assert property (@(posedge clk) disable iff (!rstN)
    (hitAcc && knownSel && lockedOut) |=> (undefExc && !rdValid));

  a_r10_wr_disable: assert property (@(posedge clk) disable iff (!rstN)
    (hitAcc && knownSel && accWrite && secPriv && secWrDisable) |=> undefExc);

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && undefExc));

  for (genvar i = 0; i < 4; i++) begin : g_evt
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[i] |=> !evtPulse[i]);
    a_r5_stops: assert property (@(posedge clk) disable iff (!rstN)
      (evtPulse[i] && !$past(startReq[i])) |-> !runFlag[i]);
  end
endmodule

bind valctr_top valctr_chk u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
  .op1(op1), .crn(crn), .crm(crm), .op2(op2),
  .secureWorld(secureWorld), .privMode(privMode),
  .userEnable(userEnable), .secWrDisable(secWrDisable),
  .startReq(startReq), .rdValid(rdValid), .undefExc(undefExc),
  .evtPulse(evtPulse), .runFlag(runFlag)
);

// File: tb/valctr_top_tb.sv
`timescale 1ns/1ps
module valctr_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0;
  logic [2:0]  op1 = '0, op2 = '0;
  logic [3:0]  crn = '0, crm = '0;
  logic [31:0] wrData = '0;
  logic        secureWorld = 1'b1, privMode = 1'b1;
  logic        userEnable = 1'b0, secWrDisable = 1'b0;
  logic [3:0]  startReq = '0;
  logic [31:0] rdData;
  logic        rdValid, undefExc;
  logic [3:0]  evtPulse;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] model [3];

  always #5 clk = ~clk;

  valctr_top u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .op1(op1), .crn(crn), .crm(crm), .op2(op2), .wrData(wrData),
    .secureWorld(secureWorld), .privMode(privMode),
    .userEnable(userEnable), .secWrDisable(secWrDisable),
    .startReq(startReq), .rdData(rdData), .rdValid(rdValid),
    .undefExc(undefExc), .evtPulse(evtPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the access edge
  task automatic acc(input bit wr, input logic [2:0] o1, input logic [3:0] n,
                     input logic [3:0] m, input logic [2:0] o2, input logic [31:0] d,
                     input bit sec, input bit pv);
    accValid = 1'b1; accWrite = wr; op1 = o1; crn = n; crm = m; op2 = o2;
    wrData = d; secureWorld = sec; privMode = pv;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] o2, input logic [31:0] d, input bit sec, input bit pv);
    acc(1'b1, 3'd0, 4'd15, 4'd12, o2, d, sec, pv);
  endtask

  task automatic rd(input logic [2:0] o2, input bit sec, input bit pv);
    acc(1'b0, 3'd0, 4'd15, 4'd12, o2, 32'h0, sec, pv);
  endtask

  task automatic kick(input logic [3:0] m);
    startReq = m;
    @(negedge clk);
    startReq = '0;
  endtask

  task automatic pulseReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic bit expUndef(bit w, bit sec, bit pv, bit ue, bit swd);
    return !((sec && pv) || ue) || (w && sec && pv && swd);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 rdValid", {31'b0, rdValid}, 32'h0);
    chk("R12 undef", {31'b0, undefExc}, 32'h0);
    chk("R12 evt", {28'b0, evtPulse}, 32'h0);
    chk("R12 rdData", rdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= 3; k++) begin
      rd(3'(k), 1'b1, 1'b1);
      chk("R12 counter zero", rdData, 32'h0);
    end

    // R1 non-matching decode is ignored
    acc(1'b1, 3'd1, 4'd15, 4'd12, 3'd1, 32'h55, 1'b1, 1'b1);
    chk("R1 miss rdValid", {31'b0, rdValid}, 32'h0);
    chk("R1 miss undef", {31'b0, undefExc}, 32'h0);
    acc(1'b1, 3'd0, 4'd14, 4'd12, 3'd1, 32'h66, 1'b1, 1'b1);
    acc(1'b1, 3'd0, 4'd15, 4'd11, 3'd1, 32'h77, 1'b1, 1'b1);
    rd(3'd1, 1'b1, 1'b1);
    chk("R1 counter untouched", rdData, 32'h0);

    // R3 unknown opcode2
    wr(3'd4, 32'h99, 1'b0, 1'b0);
    chk("R3 write undef", {31'b0, undefExc}, 32'h0);
    rd(3'd5, 1'b1, 1'b1);
    chk("R3 read rdValid", {31'b0, rdValid}, 32'h0);
    chk("R3 read undef", {31'b0, undefExc}, 32'h0);

    // R2 read/write of the three wide counters
    wr(3'd1, 32'h1111_0001, 1'b1, 1'b1);
    wr(3'd2, 32'h2222_0002, 1'b1, 1'b1);
    wr(3'd3, 32'h3333_0003, 1'b1, 1'b1);
    rd(3'd1, 1'b1, 1'b1);
    chk("R2 rdValid", {31'b0, rdValid}, 32'h1);
    chk("R2 reset ctr", rdData, 32'h1111_0001);
    rd(3'd2, 1'b1, 1'b1);
    chk("R2 irq ctr", rdData, 32'h2222_0002);
    rd(3'd3, 1'b1, 1'b1);
    chk("R2 fiq ctr", rdData, 32'h3333_0003);

    // R7 debug counter read gives zero
    wr(3'd7, 32'h0000_0015, 1'b1, 1'b1);
    rd(3'd7, 1'b1, 1'b1);
    chk("R7 rdValid", {31'b0, rdValid}, 32'h1);
    chk("R7 data", rdData, 32'h0);

    // R8 locked out when userEnable is 0
    userEnable = 1'b0;
    wr(3'd2, 32'hDEAD_BEEF, 1'b0, 1'b1);
    chk("R8 ns write undef", {31'b0, undefExc}, 32'h1);
    rd(3'd2, 1'b1, 1'b0);
    chk("R8 user read undef", {31'b0, undefExc}, 32'h1);
    chk("R8 user read rdValid", {31'b0, rdValid}, 32'h0);
    rd(3'd2, 1'b1, 1'b1);
    chk("R8 counter unchanged", rdData, 32'h2222_0002);

    // R9 userEnable opens access
    userEnable = 1'b1;
    wr(3'd2, 32'hCAFE_0009, 1'b0, 1'b0);
    chk("R9 ns write undef", {31'b0, undefExc}, 32'h0);
    rd(3'd2, 1'b0, 1'b0);
    chk("R9 ns read", rdData, 32'hCAFE_0009);
    rd(3'd7, 1'b1, 1'b0);
    chk("R9 user dbg read", rdData, 32'h0);

    // R10 secure write disable
    secWrDisable = 1'b1;
    wr(3'd3, 32'hBAD0_BAD0, 1'b1, 1'b1);
    chk("R10 write undef", {31'b0, undefExc}, 32'h1);
    rd(3'd3, 1'b1, 1'b1);
    chk("R10 read ok", {31'b0, rdValid}, 32'h1);
    chk("R10 unchanged", rdData, 32'h3333_0003);
    wr(3'd3, 32'h0101_0101, 1'b0, 1'b1);
    chk("R10 ns write allowed", {31'b0, undefExc}, 32'h0);
    rd(3'd3, 1'b1, 1'b1);
    chk("R10 ns write landed", rdData, 32'h0101_0101);

    // random permission sweep (R1 R2 R3 R8 R9 R10)
    userEnable = 1'b0; secWrDisable = 1'b0;
    for (int k = 0; k < 3; k++) begin
      model[k] = 32'h1000 * (k + 1);
      wr(3'(k + 1), model[k], 1'b1, 1'b1);
    end
    for (int it = 0; it < 400; it++) begin
      bit w, sec, pv, miss, u, known;
      logic [2:0] o2;
      logic [31:0] d;
      w = 1'($urandom); sec = 1'($urandom); pv = 1'($urandom);
      miss = (($urandom % 8) == 0);
      o2 = 3'($urandom); d = $urandom;
      userEnable = 1'($urandom); secWrDisable = 1'($urandom);
      known = (o2 == 3'd1) || (o2 == 3'd2) || (o2 == 3'd3) || (o2 == 3'd7);
      u = !miss && known && expUndef(w, sec, pv, userEnable, secWrDisable);
      acc(w, 3'd0, 4'd15, miss ? 4'd3 : 4'd12, o2, d, sec, pv);
      chk("R8 R10 random undef", {31'b0, undefExc}, {31'b0, u});
      chk("R1 R3 random rdValid", {31'b0, rdValid}, {31'b0, !miss && known && !u && !w});
      if (!miss && known && !u) begin
        if (w && o2 != 3'd7) model[o2 - 1] = d;
        if (!w) chk("R9 random data", rdData, (o2 == 3'd7) ? 32'h0 : model[o2 - 1]);
      end
    end
    userEnable = 1'b0; secWrDisable = 1'b0;

    // R4 R5 rollover of the reset counter
    wr(3'd1, 32'hFFFF_FFF0, 1'b1, 1'b1);
    kick(4'b0001);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      chk("R5 wrap pulse", {28'b0, evtPulse}, (k == 16) ? 32'h1 : 32'h0);
    end
    rd(3'd1, 1'b1, 1'b1);
    chk("R5 stopped at zero", rdData, 32'h0);

    // R6 debug counter keeps six bits
    wr(3'd7, 32'hABCD_EF3E, 1'b1, 1'b1);
    kick(4'b1000);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R6 dbg pulse", {28'b0, evtPulse}, (k == 2) ? 32'h8 : 32'h0);
    end

    // R4 steady counting
    wr(3'd2, 32'd1000, 1'b1, 1'b1);
    kick(4'b0010);
    repeat (20) @(negedge clk);
    rd(3'd2, 1'b1, 1'b1);
    chk("R4 count", rdData, 32'd1020);

    // R11 write beats increment
    wr(3'd2, 32'd5, 1'b1, 1'b1);
    rd(3'd2, 1'b1, 1'b1);
    chk("R11 loaded", rdData, 32'd5);
    rd(3'd2, 1'b1, 1'b1);
    chk("R11 R4 resumes", rdData, 32'd6);

    // R12 reset clears a running counter
    pulseReset();
    chk("R12 evt after reset", {28'b0, evtPulse}, 32'h0);
    rd(3'd2, 1'b1, 1'b1);
    chk("R12 cleared", rdData, 32'h0);
    repeat (3) @(negedge clk);
    rd(3'd2, 1'b1, 1'b1);
    chk("R12 not running", rdData, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule